// File: doc/BRIEF.md
# Multi-Owner Hardware Lock Bank

This block holds a bank of lock slots that several command channels and one CPU share to serialise access to common resources. A channel asks for a slot by presenting an extended command word carrying a slot number. The word either claims or frees the slot. The CPU does the same through a small request port. Each request that names an existing slot is answered in the same cycle with either a grant or a deny pulse. Requesters never stall: a denied requester retries later.

Every slot remembers who holds it. It records whether a channel or the CPU owns it, and which channel when the owner is a channel. A status read port returns that record for any slot, so software or a debug path can report a slot as held by channel n, held by the CPU, or free. Command parsing upstream and any interrupt signalling are handled elsewhere.

Top module: `mutex_bank`

## Requirements
- R1: A channel word is a lock command only when `ch_valid` is high for that channel and bits 31:28 equal 4'hE. Bits 27:24 equal to 0 mean claim and equal to 1 mean free. Bits 7:0 hold the slot number. Any other word gets no grant, no deny and leaves all slots unchanged.
- R2: A claim of a free slot raises the requester's grant in the same cycle. From the next cycle the slot reports the requester as owner: `stat_ch_owns`=1 with `stat_chid` equal to the channel number, or `stat_cpu_owns`=1.
- R3: A claim of a slot that is already held raises the requester's deny in the same cycle and leaves the slot unchanged.
- R4: A free request from the current owner raises its grant in the same cycle, and the slot reports unlocked from the next cycle.
- R5: A free request from any requester that does not own the slot raises its deny and leaves the slot unchanged.
- R6: When several channels claim the same free slot in one cycle, the lowest-numbered channel is granted and the others are denied.
- R7: When the CPU and a channel claim the same free slot in one cycle, the channel is granted and the CPU is denied.
- R8: A request whose slot number is NUM_SLOTS or higher gets neither grant nor deny and changes no slot.
- R9: For the slot selected by `stat_idx`, the status outputs show channel ownership, CPU ownership and the owning channel number. At most one of the two ownership bits is set. Both bits clear means unlocked. After reset every slot is unlocked.
- R10: On the CPU port, `cpu_rel`=0 requests a claim and `cpu_rel`=1 requests a free of slot `cpu_idx` while `cpu_req` is high.
- R11: Grant and deny are never both high for one requester, and neither is high without a request from that requester.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ch_valid | input | NUM_CH | Per-channel command strobe |
| ch_word | input | 32*NUM_CH | Per-channel command words, channel c at bits 32c+31:32c |
| ch_grant | output | NUM_CH | Per-channel grant, same cycle |
| ch_deny | output | NUM_CH | Per-channel deny, same cycle |
| cpu_req | input | 1 | CPU request strobe |
| cpu_rel | input | 1 | CPU request kind: 0 claim, 1 free |
| cpu_idx | input | 8 | CPU slot number |
| cpu_grant | output | 1 | CPU grant, same cycle |
| cpu_deny | output | 1 | CPU deny, same cycle |
| stat_idx | input | clog2(NUM_SLOTS) | Slot selected for status |
| stat_ch_owns | output | 1 | Selected slot held by a channel |
| stat_cpu_owns | output | 1 | Selected slot held by the CPU |
| stat_chid | output | clog2(NUM_CH) | Owning channel of the selected slot |

## Verification
Grant and deny are combinational answers to the requests of the current cycle. Ownership changes take effect at the following clock edge, and the status outputs read the registered state combinationally. The bench therefore drives requests on the falling edge and compares all responses 1 ns later against a behavioural model that has not yet been updated. The status of the selected slot is compared in that same window against the model's state before the edge. The model is updated only after the compare, so the effect of a request first shows in the status compare of the next cycle.

// File: rtl/mutex_bank.sv
module mutex_bank #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_CH    = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_CH-1:0]      ch_valid,
  input  logic [32*NUM_CH-1:0]   ch_word,
  output logic [NUM_CH-1:0]      ch_grant,
  output logic [NUM_CH-1:0]      ch_deny,
  input  logic                   cpu_req,
  input  logic                   cpu_rel,
  input  logic [7:0]             cpu_idx,
  output logic                   cpu_grant,
  output logic                   cpu_deny,
  input  logic [(NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1)-1:0] stat_idx,
  output logic                   stat_ch_owns,
  output logic                   stat_cpu_owns,
  output logic [(NUM_CH > 1 ? $clog2(NUM_CH) : 1)-1:0] stat_chid
);
  localparam int SW = NUM_SLOTS > 1 ? $clog2(NUM_SLOTS) : 1;
  localparam int CW = NUM_CH > 1 ? $clog2(NUM_CH) : 1;
  localparam logic [3:0] OP_EXT  = 4'hE;
  localparam logic [3:0] SUB_ACQ = 4'h0;
  localparam logic [3:0] SUB_REL = 4'h1;

  logic [NUM_SLOTS-1:0] chown_q, chown_d, cpuown_q, cpuown_d;
  logic [CW-1:0]        chid_q [NUM_SLOTS];
  logic [CW-1:0]        chid_d [NUM_SLOTS];

  always_comb begin
    logic [NUM_SLOTS-1:0] claimed;
    logic [31:0]          w;
    logic [SW-1:0]        s;
    logic                 inr;
    chown_d   = chown_q;
    cpuown_d  = cpuown_q;
    chid_d    = chid_q;
    claimed   = '0;
    ch_grant  = '0;
    ch_deny   = '0;
    cpu_grant = 1'b0;
    cpu_deny  = 1'b0;
    for (int c = 0; c < NUM_CH; c++) begin
      w   = ch_word[32*c +: 32];
      s   = w[SW-1:0];
      inr = 32'(w[7:0]) < NUM_SLOTS;
      if (ch_valid[c] && inr && w[31:28] == OP_EXT) begin
        if (w[27:24] == SUB_ACQ) begin
          if (!chown_q[s] && !cpuown_q[s] && !claimed[s]) begin
            ch_grant[c] = 1'b1;
            claimed[s]  = 1'b1;
            chown_d[s]  = 1'b1;
            chid_d[s]   = CW'(c);
          end else begin
            ch_deny[c] = 1'b1;
          end
        end else if (w[27:24] == SUB_REL) begin
          if (chown_q[s] && chid_q[s] == CW'(c)) begin
            ch_grant[c] = 1'b1;
            chown_d[s]  = 1'b0;
          end else begin
            ch_deny[c] = 1'b1;
          end
        end
      end
    end
    s   = cpu_idx[SW-1:0];
    inr = 32'(cpu_idx) < NUM_SLOTS;
    if (cpu_req && inr) begin
      if (!cpu_rel) begin
        if (!chown_q[s] && !cpuown_q[s] && !claimed[s]) begin
          cpu_grant   = 1'b1;
          cpuown_d[s] = 1'b1;
        end else begin
          cpu_deny = 1'b1;
        end
      end else begin
        if (cpuown_q[s]) begin
          cpu_grant   = 1'b1;
          cpuown_d[s] = 1'b0;
        end else begin
          cpu_deny = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chown_q  <= '0;
      cpuown_q <= '0;
      chid_q   <= '{default: '0};
    end else begin
      chown_q  <= chown_d;
      cpuown_q <= cpuown_d;
      chid_q   <= chid_d;
    end
  end

  assign stat_ch_owns  = chown_q[stat_idx];
  assign stat_cpu_owns = cpuown_q[stat_idx];
  assign stat_chid     = chid_q[stat_idx];
endmodule

// File: rtl/mutex_bank_chk.sv
module mutex_bank_chk #(
  parameter int NUM_SLOTS = 16,
  parameter int NUM_CH    = 4
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    ch_valid,
  input logic [NUM_CH-1:0]    ch_grant,
  input logic [NUM_CH-1:0]    ch_deny,
  input logic                 cpu_req,
  input logic                 cpu_rel,
  input logic [7:0]           cpu_idx,
  input logic                 cpu_grant,
  input logic                 cpu_deny,
  input logic [NUM_SLOTS-1:0] chown_q,
  input logic [NUM_SLOTS-1:0] cpuown_q
);
  p_excl_resp_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ch_grant & ch_deny) == '0 && !(cpu_grant && cpu_deny));

  p_resp_needs_req_r11: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_grant | ch_deny) & ~ch_valid) == '0 && (!(cpu_grant || cpu_deny) || cpu_req));

  p_single_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (chown_q & cpuown_q) == '0);

  p_oor_silent_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && 32'(cpu_idx) >= NUM_SLOTS |-> !cpu_grant && !cpu_deny);

  p_idle_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ch_valid == '0 && !cpu_req |=> $stable(chown_q) && $stable(cpuown_q));

  p_cpu_claim_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && !cpu_rel && cpu_grant |=> $countones(cpuown_q) == $past($countones(cpuown_q)) + 1);

  p_cpu_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_rel && cpu_grant |=> $countones(cpuown_q) + 1 == $past($countones(cpuown_q)));
endmodule

bind mutex_bank mutex_bank_chk #(.NUM_SLOTS(NUM_SLOTS), .NUM_CH(NUM_CH)) u_chk (
  .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_grant(ch_grant),
  .ch_deny(ch_deny), .cpu_req(cpu_req), .cpu_rel(cpu_rel), .cpu_idx(cpu_idx),
  .cpu_grant(cpu_grant), .cpu_deny(cpu_deny), .chown_q(chown_q), .cpuown_q(cpuown_q)
);

// File: tb/tb_mutex_bank.sv
module tb_mutex_bank;
  localparam int NS  = 16;
  localparam int NCH = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NCH-1:0]  ch_valid = '0;
  logic [32*NCH-1:0] ch_word = '0;
  logic [NCH-1:0]  ch_grant, ch_deny;
  logic            cpu_req = 1'b0, cpu_rel = 1'b0;
  logic [7:0]      cpu_idx = '0;
  logic            cpu_grant, cpu_deny;
  logic [3:0]      stat_idx = '0;
  logic            stat_ch_owns, stat_cpu_owns;
  logic [1:0]      stat_chid;

  int checks = 0;
  int errors = 0;
  int m_ch[NS], m_cpu[NS], m_id[NS];

  always #5 clk = ~clk;

  mutex_bank #(.NUM_SLOTS(NS), .NUM_CH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .ch_valid(ch_valid), .ch_word(ch_word),
    .ch_grant(ch_grant), .ch_deny(ch_deny), .cpu_req(cpu_req), .cpu_rel(cpu_rel),
    .cpu_idx(cpu_idx), .cpu_grant(cpu_grant), .cpu_deny(cpu_deny),
    .stat_idx(stat_idx), .stat_ch_owns(stat_ch_owns), .stat_cpu_owns(stat_cpu_owns),
    .stat_chid(stat_chid)
  );

  function automatic logic [31:0] cmd(input logic [3:0] op, input logic [3:0] sub, input logic [7:0] idx);
    return {op, sub, 16'h0000, idx};
  endfunction

  task automatic step(input string tag, input logic [NCH-1:0] v,
                      input logic [31:0] w0, input logic [31:0] w1,
                      input logic [31:0] w2, input logic [31:0] w3,
                      input logic creq, input logic crel, input logic [7:0] cidx,
                      input int sidx);
    int claimed[NS];
    int n_ch[NS], n_cpu[NS], n_id[NS];
    logic [NCH-1:0] eg, ed;
    logic cg, cd;
    logic [31:0] w;
    int ix;
    @(negedge clk);
    ch_valid = v; ch_word = {w3, w2, w1, w0};
    cpu_req = creq; cpu_rel = crel; cpu_idx = cidx; stat_idx = 4'(sidx);
    #1;
    for (int i = 0; i < NS; i++) begin
      claimed[i] = 0; n_ch[i] = m_ch[i]; n_cpu[i] = m_cpu[i]; n_id[i] = m_id[i];
    end
    eg = '0; ed = '0; cg = 1'b0; cd = 1'b0;
    for (int c = 0; c < NCH; c++) begin
      w = ch_word[32*c +: 32];
      ix = int'(w[7:0]);
      if (v[c] && w[31:28] == 4'hE && ix < NS) begin
        if (w[27:24] == 4'h0) begin
          if (m_ch[ix] == 0 && m_cpu[ix] == 0 && claimed[ix] == 0) begin
            eg[c] = 1'b1; claimed[ix] = 1; n_ch[ix] = 1; n_id[ix] = c;
          end else ed[c] = 1'b1;
        end else if (w[27:24] == 4'h1) begin
          if (m_ch[ix] == 1 && m_id[ix] == c) begin
            eg[c] = 1'b1; n_ch[ix] = 0;
          end else ed[c] = 1'b1;
        end
      end
    end
    ix = int'(cidx);
    if (creq && ix < NS) begin
      if (!crel) begin
        if (m_ch[ix] == 0 && m_cpu[ix] == 0 && claimed[ix] == 0) begin
          cg = 1'b1; n_cpu[ix] = 1;
        end else cd = 1'b1;
      end else begin
        if (m_cpu[ix] == 1) begin
          cg = 1'b1; n_cpu[ix] = 0;
        end else cd = 1'b1;
      end
    end
    checks++;
    if (ch_grant !== eg || ch_deny !== ed) begin
      errors++;
      $display("FAIL %s channel resp: grant=%b deny=%b expected grant=%b deny=%b", tag, ch_grant, ch_deny, eg, ed);
    end
    checks++;
    if (cpu_grant !== cg || cpu_deny !== cd) begin
      errors++;
      $display("FAIL %s cpu resp: grant=%b deny=%b expected grant=%b deny=%b", tag, cpu_grant, cpu_deny, cg, cd);
    end
    checks++;
    if (stat_ch_owns !== (m_ch[sidx] == 1) || stat_cpu_owns !== (m_cpu[sidx] == 1) ||
        (m_ch[sidx] == 1 && int'(stat_chid) != m_id[sidx])) begin
      errors++;
      $display("FAIL %s status slot %0d: ch=%b cpu=%b id=%0d expected ch=%0d cpu=%0d id=%0d",
               tag, sidx, stat_ch_owns, stat_cpu_owns, stat_chid, m_ch[sidx], m_cpu[sidx], m_id[sidx]);
    end
    for (int i = 0; i < NS; i++) begin
      m_ch[i] = n_ch[i]; m_cpu[i] = n_cpu[i]; m_id[i] = n_id[i];
    end
  endtask

  task automatic idle(input string tag, input int sidx);
    step(tag, '0, '0, '0, '0, '0, 1'b0, 1'b0, 8'd0, sidx);
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin
      m_ch[i] = 0; m_cpu[i] = 0; m_id[i] = 0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R9: every slot unlocked after reset
    for (int i = 0; i < NS; i++) idle("R9", i);
    // R2: channel 1 claims slot 3
    step("R2", 4'b0010, '0, cmd(4'hE, 4'h0, 8'd3), '0, '0, 1'b0, 1'b0, 8'd0, 3);
    idle("R2", 3);
    // R3: claims of a held slot, channel and CPU
    step("R3", 4'b0100, '0, '0, cmd(4'hE, 4'h0, 8'd3), '0, 1'b1, 1'b0, 8'd3, 3);
    // R10: CPU claims slot 5
    step("R10", '0, '0, '0, '0, '0, 1'b1, 1'b0, 8'd5, 3);
    idle("R10", 5);
    // R5: frees from non-owners
    step("R5", 4'b0001, cmd(4'hE, 4'h1, 8'd3), '0, '0, '0, 1'b1, 1'b1, 8'd3, 3);
    step("R5", 4'b1000, '0, '0, '0, cmd(4'hE, 4'h1, 8'd5), 1'b0, 1'b0, 8'd0, 5);
    // R4: owner frees slot 3
    step("R4", 4'b0010, '0, cmd(4'hE, 4'h1, 8'd3), '0, '0, 1'b0, 1'b0, 8'd0, 3);
    idle("R4", 3);
    // R6: three channels race for slot 7
    step("R6", 4'b1101, cmd(4'hE, 4'h0, 8'd7), '0, cmd(4'hE, 4'h0, 8'd7), cmd(4'hE, 4'h0, 8'd7), 1'b0, 1'b0, 8'd0, 7);
    idle("R6", 7);
    // R7: channel beats CPU for slot 9
    step("R7", 4'b1000, '0, '0, '0, cmd(4'hE, 4'h0, 8'd9), 1'b1, 1'b0, 8'd9, 9);
    idle("R7", 9);
    // R1: non-lock words are ignored
    step("R1", 4'b0111, cmd(4'h1, 4'h0, 8'd10), cmd(4'hE, 4'h2, 8'd10), cmd(4'h0, 4'h1, 8'd9), '0, 1'b0, 1'b0, 8'd0, 10);
    step("R1", 4'b0000, cmd(4'hE, 4'h0, 8'd10), '0, '0, '0, 1'b0, 1'b0, 8'd0, 10);
    idle("R1", 10);
    // R8: out-of-range slot numbers
    step("R8", 4'b0011, cmd(4'hE, 4'h0, 8'd16), cmd(4'hE, 4'h0, 8'd200), '0, '0, 1'b1, 1'b0, 8'd16, 0);
    step("R8", '0, '0, '0, '0, '0, 1'b1, 1'b1, 8'd255, 0);
    // R4: CPU frees slot 5; R5: same-cycle free by owner and claim by another
    step("R4", '0, '0, '0, '0, '0, 1'b1, 1'b1, 8'd5, 5);
    step("R5", 4'b0011, cmd(4'hE, 4'h1, 8'd7), cmd(4'hE, 4'h0, 8'd7), '0, '0, 1'b0, 1'b0, 8'd0, 7);
    // R2: freed slot can be reclaimed by the CPU next cycle
    step("R2", '0, '0, '0, '0, '0, 1'b1, 1'b0, 8'd7, 7);
    // R11: mixed traffic on distinct slots in one cycle
    step("R11", 4'b1111, cmd(4'hE, 4'h0, 8'd0), cmd(4'hE, 4'h0, 8'd1), cmd(4'hE, 4'h0, 8'd15), cmd(4'hE, 4'h1, 8'd9), 1'b1, 1'b0, 8'd2, 9);
    for (int i = 0; i < NS; i++) idle("R9", i);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule